// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block is the host-side engine for reading from an 8-bit NAND flash device. A client hands it a row, a column and a byte count on a request port. The block then drives the command latch, address latch, write strobe, read strobe and data bus to load that page into the device's page register. It waits for the ready/busy line to show that the array sense has finished, then strobes the requested bytes out. The bytes are returned on a valid/ready stream, and one response word reports how the request ended.

A second kind of request, the column jump, reuses the page already held in the device register. It sends a short column-change command with only two column address bytes, does not wait for busy, and carries on reading from the new column. Jumps may be repeated as often as needed on the same loaded page. Every page has a main field followed by a spare field, and any column below the page size is accepted in either field.

Strobe widths, the busy-start allowance and the busy timeout are parameters counted in system clock cycles.

Top module: `nand_page_reader`

## Requirements
- R1: A full read puts these bus cycles on the bus in this order: command 0x00, then four address bytes, then command 0x30. The address bytes are column low byte, column high byte (upper column bits, zero-extended), row low byte and row high byte. Command bytes are driven with CLE high and ALE low, address bytes with ALE high and CLE low. The device latches each byte on the rising edge of WE#, with the bus output enable high.
- R2: Every WE# pulse is low for exactly WE_LO cycles, and every RE# pulse is low for exactly RE_LO cycles. WE# and RE# are never low together, and CLE and ALE are never high together.
- R3: After command 0x30, no RE# strobe starts until ready/busy has gone low and then returned high.
- R4: A request returns exactly its byte count of bytes, taken from consecutive columns starting at the requested column of the loaded page. out_last is high on the final byte only. While out_valid is high and out_ready is low, out_data holds steady.
- R5: A column jump sends command 0x05, column low byte, column high byte, then command 0xE0. It sends no 0x30, no row bytes and does no busy wait, and the data continues from the new column of the loaded page. The jump can be repeated.
- R6: A request whose column is PAGE_BYTES or more ends with response code 1 and causes no bus cycle. Column PAGE_BYTES-1, in the spare field, is accepted.
- R7: A column jump made when no page is loaded, either after reset or after a timeout, ends with response code 1 and causes no bus cycle.
- R8: If the busy wait lasts TIMEOUT cycles, the request ends with response code 2. No data is strobed, and the page counts as not loaded.
- R9: After the last byte is accepted, resp_valid is high for one cycle with code 0. req_ready is high only while the block is idle.
- R10: During and straight after reset, CLE and ALE are low, WE# and RE# are high, the bus output enable is low, out_valid and resp_valid are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | block idle, request accepted |
| req_jump | input | 1 | 1 = column jump in loaded page, 0 = full page read |
| req_row | input | ROW_W | page row address |
| req_col | input | COL_W | starting column |
| req_len | input | LEN_W | number of bytes to return |
| out_valid | output | 1 | read byte available |
| out_ready | input | 1 | consumer takes the byte |
| out_data | output | 8 | read byte |
| out_last | output | 1 | final byte of the request |
| resp_valid | output | 1 | request finished (one cycle) |
| resp_code | output | 2 | 0 ok, 1 rejected, 2 busy timeout |
| nand_cle | output | 1 | command latch enable |
| nand_ale | output | 1 | address latch enable |
| nand_we_n | output | 1 | write strobe, active low |
| nand_re_n | output | 1 | read strobe, active low |
| nand_dq_out | output | 8 | bus value driven by the host |
| nand_dq_oe | output | 1 | host drives the bus |
| nand_dq_in | input | 8 | bus value driven by the device |
| nand_rb | input | 1 | ready (1) / busy (0) |

## Verification
The bench builds the block with WE_LO=2, WE_HI=1, RE_LO=3 and RE_HI=1, so that write and read strobe widths differ and a width mix-up shows at once. T_WB is 8, which covers the modelled two-cycle busy onset plus the two-flop synchronizer. TIMEOUT is 150, so a modelled sense time of 400 cycles reaches the timeout path within a short run, while the normal 20-cycle sense time completes. PAGE_BYTES is kept at 2112, so the spare-field column 2100, the last column 2111 and the rejected column 2112 are all exercised.

// File: rtl/nandrd_pkg.sv
// Shared types and constants of the NAND page read sequencer.
// Assumes an 8-bit device bus with two column and two row address bytes.
package nandrd_pkg;
    typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_RD} bus_kind_t;

    localparam logic [7:0] OP_PAGE_SETUP = 8'h00;
    localparam logic [7:0] OP_PAGE_GO    = 8'h30;
    localparam logic [7:0] OP_JUMP_SETUP = 8'h05;
    localparam logic [7:0] OP_JUMP_GO    = 8'hE0;

    localparam logic [1:0] RC_OK      = 2'd0;
    localparam logic [1:0] RC_REJECT  = 2'd1;
    localparam logic [1:0] RC_TIMEOUT = 2'd2;
endpackage

// File: rtl/nandrd_strobe.sv
// One device bus cycle: a command or address write (WE# pulse) or a data
// read (RE# pulse). The strobe is low for the LO count, then high for the HI
// count. CLE/ALE/data stay valid for the whole cycle, so the byte is stable
// at the rising WE# edge. A read byte is captured in the last low cycle.
// Assumes all widths are at least 1 and start is only given when idle.
module nandrd_strobe
    import nandrd_pkg::*;
#(
    parameter int WE_LO = 2,
    parameter int WE_HI = 2,
    parameter int RE_LO = 2,
    parameter int RE_HI = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  bus_kind_t  kind,
    input  logic [7:0] wbyte,
    output logic       done,
    output logic [7:0] rbyte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    input  logic [7:0] dq_in
);
    localparam int MAXW = (WE_LO > WE_HI ? WE_LO : WE_HI) > (RE_LO > RE_HI ? RE_LO : RE_HI)
                        ? (WE_LO > WE_HI ? WE_LO : WE_HI) : (RE_LO > RE_HI ? RE_LO : RE_HI);
    localparam int CW = $clog2(MAXW + 1);
    localparam logic [CW-1:0] WLO_L = CW'(WE_LO - 1);
    localparam logic [CW-1:0] WHI_L = CW'(WE_HI - 1);
    localparam logic [CW-1:0] RLO_L = CW'(RE_LO - 1);
    localparam logic [CW-1:0] RHI_L = CW'(RE_HI - 1);

    logic          act, hi_ph;
    logic [CW-1:0] cnt;
    bus_kind_t     kind_q;
    logic [7:0]    byte_q;
    logic [CW-1:0] lo_lim, hi_lim;

    // Phase limits for the cycle kind in progress.
    always_comb begin
        lo_lim = (kind_q == BK_RD) ? RLO_L : WLO_L;
        hi_lim = (kind_q == BK_RD) ? RHI_L : WHI_L;
    end

    // Phase and count register; latches the request and the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= 1'b0;
            hi_ph  <= 1'b0;
            cnt    <= '0;
            kind_q <= BK_CMD;
            byte_q <= '0;
            rbyte  <= '0;
        end else if (start) begin
            act    <= 1'b1;
            hi_ph  <= 1'b0;
            cnt    <= '0;
            kind_q <= kind;
            byte_q <= wbyte;
        end else if (act) begin
            if (!hi_ph) begin
                if (cnt == lo_lim) begin
                    hi_ph <= 1'b1;
                    cnt   <= '0;
                    if (kind_q == BK_RD) rbyte <= dq_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (cnt == hi_lim) begin
                act <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Bus pins decoded from the phase registers.
    always_comb begin
        done   = act && hi_ph && (cnt == hi_lim);
        cle    = act && (kind_q == BK_CMD);
        ale    = act && (kind_q == BK_ADDR);
        we_n   = !(act && !hi_ph && (kind_q != BK_RD));
        re_n   = !(act && !hi_ph && (kind_q == BK_RD));
        dq_oe  = act && (kind_q != BK_RD);
        dq_out = byte_q;
    end

    // A new cycle is only started once the previous one has finished.
    assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !act);
endmodule

// File: rtl/nandrd_busywait.sv
// Waits out the array sense after the page confirm command. It first waits
// until ready/busy is seen low or T_WB cycles pass, then waits for ready
// again. If the whole wait reaches TIMEOUT cycles it reports a timeout.
// Assumes T_WB covers the device busy onset plus the 2-flop synchronizer.
module nandrd_busywait #(
    parameter int T_WB    = 8,
    parameter int TIMEOUT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rb,
    output logic done,
    output logic tout
);
    localparam int WW = $clog2(T_WB + 1);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [WW-1:0] WB_LAST = WW'(T_WB - 1);
    localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT - 1);

    typedef enum logic [1:0] {BW_IDLE, BW_LOW, BW_HIGH} bw_st_t;
    bw_st_t        st;
    logic [WW-1:0] wb_cnt;
    logic [TW-1:0] to_cnt;
    logic          rb_s1, rb_s2;

    // Bring the asynchronous ready/busy line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_s1 <= 1'b1;
            rb_s2 <= 1'b1;
        end else begin
            rb_s1 <= rb;
            rb_s2 <= rb_s1;
        end
    end

    // Completion and timeout pulses.
    always_comb begin
        done = (st == BW_HIGH) && rb_s2;
        tout = (st != BW_IDLE) && (to_cnt == TO_LAST) && !done;
    end

    // Wait phases with the busy-onset and timeout counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= BW_IDLE;
            wb_cnt <= '0;
            to_cnt <= '0;
        end else if (start) begin
            st     <= BW_LOW;
            wb_cnt <= '0;
            to_cnt <= '0;
        end else if (st != BW_IDLE) begin
            to_cnt <= to_cnt + 1'b1;
            if (done || tout) begin
                st <= BW_IDLE;
            end else if (st == BW_LOW) begin
                if (!rb_s2 || wb_cnt == WB_LAST) st <= BW_HIGH;
                else wb_cnt <= wb_cnt + 1'b1;
            end
        end
    end

    // A wait is only started when none is running.
    assert_wait_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> st == BW_IDLE);
endmodule

// File: rtl/nand_page_reader.sv
// Top of the NAND page read sequencer. It accepts a request, rejects bad
// columns and jumps with no loaded page, and steps through the command and
// address cycles. After a full read it waits for the sense, then reads
// bytes one strobe at a time into a valid/ready stream and ends with one
// response. Assumes ROW_W <= 16 and a column that fits two address bytes.
module nand_page_reader
    import nandrd_pkg::*;
#(
    parameter int PAGE_BYTES = 2112,
    parameter int ROW_W      = 16,
    parameter int WE_LO      = 2,
    parameter int WE_HI      = 2,
    parameter int RE_LO      = 2,
    parameter int RE_HI      = 2,
    parameter int T_WB       = 8,
    parameter int TIMEOUT    = 100000,
    localparam int COL_W     = $clog2(PAGE_BYTES),
    localparam int LEN_W     = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_jump,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb
);
    localparam logic [COL_W:0] COL_LIM = (COL_W + 1)'(PAGE_BYTES);

    typedef enum logic [2:0] {S_IDLE, S_BUS, S_WAIT, S_DATA, S_OUT, S_RESP} seq_st_t;
    seq_st_t          st;
    logic             jump_q, launched, loaded;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] left_q;
    logic [2:0]       step;
    logic [1:0]       code_q;
    logic [7:0]       byte_q;

    logic             stb_start, stb_done, bw_start, bw_done, bw_tout;
    bus_kind_t        stb_kind;
    logic [7:0]       stb_wbyte, stb_rbyte;
    logic [15:0]      col_pad, row_pad;
    logic [2:0]       last_step;

    // Selects the kind and byte of the current bus step.
    always_comb begin
        col_pad   = 16'(col_q);
        row_pad   = 16'(row_q);
        last_step = jump_q ? 3'd3 : 3'd5;
        stb_kind  = BK_ADDR;
        stb_wbyte = 8'h00;
        if (st == S_DATA) begin
            stb_kind = BK_RD;
        end else begin
            case (step)
                3'd0: begin stb_kind = BK_CMD; stb_wbyte = jump_q ? OP_JUMP_SETUP : OP_PAGE_SETUP; end
                3'd1: stb_wbyte = col_pad[7:0];
                3'd2: stb_wbyte = col_pad[15:8];
                3'd3: if (jump_q) begin stb_kind = BK_CMD; stb_wbyte = OP_JUMP_GO; end
                      else stb_wbyte = row_pad[7:0];
                3'd4: stb_wbyte = row_pad[15:8];
                default: begin stb_kind = BK_CMD; stb_wbyte = OP_PAGE_GO; end
            endcase
        end
        stb_start = (st == S_BUS || st == S_DATA) && !launched;
        bw_start  = (st == S_WAIT) && !launched;
    end

    // Request sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; jump_q <= 1'b0; launched <= 1'b0; loaded <= 1'b0;
            row_q <= '0; col_q <= '0; left_q <= '0; step <= '0;
            code_q <= RC_OK; byte_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    jump_q <= req_jump; row_q <= req_row; col_q <= req_col;
                    left_q <= req_len; step <= '0; launched <= 1'b0;
                    if ({1'b0, req_col} >= COL_LIM || (req_jump && !loaded)) begin
                        code_q <= RC_REJECT; st <= S_RESP;
                    end else begin
                        code_q <= RC_OK; st <= S_BUS;
                    end
                end
                S_BUS: begin
                    if (stb_start) launched <= 1'b1;
                    if (stb_done) begin
                        launched <= 1'b0;
                        if (step == last_step) begin
                            step <= '0;
                            if (!jump_q) st <= S_WAIT;
                            else st <= (left_q == '0) ? S_RESP : S_DATA;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                end
                S_WAIT: begin
                    if (bw_start) launched <= 1'b1;
                    if (bw_done) begin
                        launched <= 1'b0; loaded <= 1'b1;
                        st <= (left_q == '0) ? S_RESP : S_DATA;
                    end else if (bw_tout) begin
                        launched <= 1'b0; loaded <= 1'b0;
                        code_q <= RC_TIMEOUT; st <= S_RESP;
                    end
                end
                S_DATA: begin
                    if (stb_start) launched <= 1'b1;
                    if (stb_done) begin
                        launched <= 1'b0; byte_q <= stb_rbyte; st <= S_OUT;
                    end
                end
                S_OUT: if (out_ready) begin
                    left_q <= left_q - 1'b1;
                    st <= (left_q == LEN_W'(1)) ? S_RESP : S_DATA;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Client-facing outputs.
    always_comb begin
        req_ready  = (st == S_IDLE);
        out_valid  = (st == S_OUT);
        out_data   = byte_q;
        out_last   = (st == S_OUT) && (left_q == LEN_W'(1));
        resp_valid = (st == S_RESP);
        resp_code  = code_q;
    end

    nandrd_strobe #(.WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI)) u_strobe (
        .clk(clk), .rst_n(rst_n), .start(stb_start), .kind(stb_kind), .wbyte(stb_wbyte),
        .done(stb_done), .rbyte(stb_rbyte), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
        .dq_in(nand_dq_in)
    );

    nandrd_busywait #(.T_WB(T_WB), .TIMEOUT(TIMEOUT)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(bw_start), .rb(nand_rb),
        .done(bw_done), .tout(bw_tout)
    );

    // A byte offered to the consumer stays put until it is taken.
    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // A rejection follows a cycle with no strobe on the bus.
    assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_code == RC_REJECT |-> $past(nand_we_n) && $past(nand_re_n));
    // A column jump never enters the busy wait.
    assert_jump_no_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_WAIT |-> !jump_q);
endmodule

// File: tb/nand_page_reader_test.sv
// Bench: a behavioural device model with a page register and ready/busy
// timing, plus per-clock comparison of bus cycles, strobe widths, stream
// bytes and responses against queues filled from the requirements.
module nand_page_reader_test;
    localparam int PB = 2112, WLO = 2, WHI = 1, RLO = 3, RHI = 1, TWB = 8, TOUT = 150;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_jump = 1'b0, out_ready = 1'b1;
    logic [15:0] req_row = '0;
    logic [11:0] req_col = '0, req_len = '0;
    logic req_ready, out_valid, out_last, resp_valid;
    logic [7:0] out_data, dq_out, dq_in = 8'h00;
    logic [1:0] resp_code;
    logic cle, ale, we_n, re_n, dq_oe, rb = 1'b1;

    always #4 clk = ~clk;

    nand_page_reader #(.PAGE_BYTES(PB), .ROW_W(16), .WE_LO(WLO), .WE_HI(WHI), .RE_LO(RLO),
        .RE_HI(RHI), .T_WB(TWB), .TIMEOUT(TOUT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_jump(req_jump), .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .resp_valid(resp_valid), .resp_code(resp_code), .nand_cle(cle), .nand_ale(ale),
        .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_out(dq_out), .nand_dq_oe(dq_oe),
        .nand_dq_in(dq_in), .nand_rb(rb));

    int checks = 0, fails = 0, cyc = 0, ev_count = 0, re_count = 0;
    bit finished = 1'b0, bp_mode = 1'b0;
    logic [9:0] exp_ev[$];
    logic [8:0] exp_data[$];
    int exp_resp[$];
    // device model state
    int m_mode = 0, m_n = 0, m_row = 0, m_ptr = 0, busy_delay = 0, busy_left = 0, tr = 20;
    logic [7:0] m_addr[4];
    int we_run = 0, re_run = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;

    function automatic logic [7:0] pdata(int row, int col);
        return 8'(row * 13 + col * 7 + (col >> 8));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-clock model and comparison, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(!(cle && ale), "R2", "cle/ale overlap", int'({cle, ale}), 0);
            check(we_n || re_n, "R2", "we/re overlap", int'({we_n, re_n}), 3);
            if (!we_n) we_run++;
            else if (!prev_we) begin
                logic [9:0] ev, ex;
                ev = {cle, ale, dq_out};
                ev_count++;
                check(we_run == WLO, "R2", "WE# low width", we_run, WLO);
                check(dq_oe, "R1", "bus enable at latch", int'(dq_oe), 1);
                ex = (exp_ev.size() > 0) ? exp_ev.pop_front() : 10'h3FF;
                check(ev == ex, "R1", "bus cycle {cle,ale,byte}", int'(ev), int'(ex));
                we_run = 0;
                if (cle) begin
                    case (dq_out)
                        8'h00: begin m_mode = 1; m_n = 0; end
                        8'h05: begin m_mode = 2; m_n = 0; end
                        8'h30: if (m_mode == 1 && m_n == 4) begin
                            m_row = {m_addr[3], m_addr[2]}; m_ptr = {m_addr[1], m_addr[0]};
                            busy_delay = 2; m_mode = 0;
                        end
                        8'hE0: if (m_mode == 2 && m_n == 2) begin
                            m_ptr = {m_addr[1], m_addr[0]}; m_mode = 0;
                        end
                        default: m_mode = 0;
                    endcase
                end else if (ale) begin
                    if (m_n < 4) m_addr[m_n] = dq_out;
                    m_n++;
                end
            end
            if (!re_n) begin
                if (prev_re) begin
                    re_count++;
                    check(rb && busy_delay == 0, "R3", "read strobe while busy", int'(rb), 1);
                    dq_in = pdata(m_row, m_ptr);
                end
                re_run++;
            end else if (!prev_re) begin
                check(re_run == RLO, "R2", "RE# low width", re_run, RLO);
                re_run = 0;
                m_ptr++;
            end
            prev_we = we_n;
            prev_re = re_n;
            if (busy_delay > 0) begin
                busy_delay--;
                if (busy_delay == 0) begin rb = 1'b0; busy_left = tr; end
            end else if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) rb = 1'b1;
            end
            out_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
            if (out_valid && out_ready) begin
                logic [8:0] ex;
                ex = (exp_data.size() > 0) ? exp_data.pop_front() : 9'h1FF;
                check({out_last, out_data} == ex, "R4", "stream {last,byte}",
                      int'({out_last, out_data}), int'(ex));
            end
            if (resp_valid) begin
                int ex;
                ex = (exp_resp.size() > 0) ? exp_resp.pop_front() : -1;
                check(int'(resp_code) == ex, "R9", "response code", int'(resp_code), ex);
            end
        end
    end

    task automatic push_full(int row, int col);
        exp_ev.push_back({2'b10, 8'h00});
        exp_ev.push_back({2'b01, 8'(col)});
        exp_ev.push_back({2'b01, 8'(col >> 8)});
        exp_ev.push_back({2'b01, 8'(row)});
        exp_ev.push_back({2'b01, 8'(row >> 8)});
        exp_ev.push_back({2'b10, 8'h30});
    endtask

    task automatic push_jump(int col);
        exp_ev.push_back({2'b10, 8'h05});
        exp_ev.push_back({2'b01, 8'(col)});
        exp_ev.push_back({2'b01, 8'(col >> 8)});
        exp_ev.push_back({2'b10, 8'hE0});
    endtask

    task automatic push_data(int row, int col, int len);
        for (int i = 0; i < len; i++)
            exp_data.push_back({(i == len - 1) ? 1'b1 : 1'b0, pdata(row, col + i)});
    endtask

    task automatic send(bit jump, int row, int col, int len);
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b1; req_jump = jump;
        req_row = 16'(row); req_col = 12'(col); req_len = 12'(len);
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_resp.size() > 0) @(negedge clk);
        check(exp_ev.size() == 0, "R1", "bus cycles left over", exp_ev.size(), 0);
        check(exp_data.size() == 0, "R4", "bytes left over", exp_data.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int evb, reb;
        repeat (5) @(negedge clk);
        // R10 reset levels
        check({cle, ale, we_n, re_n, dq_oe} == 5'b00110, "R10", "bus idle in reset",
              int'({cle, ale, we_n, re_n, dq_oe}), 6);
        rst_n = 1'b1;
        @(negedge clk);
        check({out_valid, resp_valid, req_ready} == 3'b001, "R10", "client idle after reset",
              int'({out_valid, resp_valid, req_ready}), 1);
        // R7 jump with nothing loaded
        evb = ev_count; exp_resp.push_back(1);
        send(1'b1, 0, 10, 2);
        check(ev_count == evb, "R7", "bus cycles on unloaded jump", ev_count - evb, 0);
        // R1 R3 R4 R9 full read
        push_full(16'h1234, 5); push_data(16'h1234, 5, 4); exp_resp.push_back(0);
        send(1'b0, 16'h1234, 5, 4);
        // R5 jump into spare field, with backpressure
        bp_mode = 1'b1;
        push_jump(2100); push_data(16'h1234, 2100, 3); exp_resp.push_back(0);
        send(1'b1, 0, 2100, 3);
        check(rb == 1'b1 && busy_delay == 0, "R5", "no sense after jump", int'(rb), 1);
        // R5 repeated jump
        push_jump(0); push_data(16'h1234, 0, 2); exp_resp.push_back(0);
        send(1'b1, 0, 0, 2);
        // R6 column too large
        evb = ev_count; exp_resp.push_back(1);
        send(1'b0, 3, PB, 1);
        check(ev_count == evb, "R6", "bus cycles on bad column", ev_count - evb, 0);
        // R6 last spare column accepted
        bp_mode = 1'b0;
        push_full(16'h00A5, PB - 1); push_data(16'h00A5, PB - 1, 1); exp_resp.push_back(0);
        send(1'b0, 16'h00A5, PB - 1, 1);
        // R4 longer read under backpressure
        bp_mode = 1'b1;
        push_full(7, 300); push_data(7, 300, 6); exp_resp.push_back(0);
        send(1'b0, 7, 300, 6);
        // R8 busy timeout
        bp_mode = 1'b0; tr = 400; reb = re_count;
        push_full(16'hBEEF, 40); exp_resp.push_back(2);
        send(1'b0, 16'hBEEF, 40, 3);
        check(re_count == reb, "R8", "read strobes after timeout", re_count - reb, 0);
        repeat (450) @(negedge clk);
        tr = 20;
        // R7 jump after timeout is rejected
        evb = ev_count; exp_resp.push_back(1);
        send(1'b1, 0, 1, 1);
        check(ev_count == evb, "R7", "bus cycles on jump after timeout", ev_count - evb, 0);
        // R1 normal read after recovery
        push_full(16'h0102, 2048); push_data(16'h0102, 2048, 2); exp_resp.push_back(0);
        send(1'b0, 16'h0102, 2048, 2);
        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule